// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block divides a fast oscillator clock by a programmable integer for the feedback path of an integer-N synthesizer. It does not use one wide loadable counter. A small prescaler toggles between two moduli, P+1 and P. A 5-bit swallow count sets how many prescaler periods use P+1, and a 13-bit main count sets the total number of prescaler periods. The result is a ratio of N = B·P + A input clocks per output pulse. The pair P/P+1 is chosen by a 2-bit select: 8/9, 16/17 or 32/33.

The block samples the swallow count, the main count and the select at a reload boundary. Two things create a reload boundary: the end of every division period, and the first clock after reset. A new setting therefore never cuts a period short. The block checks each sampled setting. If the main count is smaller than the swallow count, or smaller than three, the block raises an error flag and stops pulsing. It then samples again on every clock until it sees a legal setting. A status output shows when the prescaler is running at P+1.

Top module: `pulse_swallow_div`

## Requirements
- R1: The select code picks the modulus pair. 2'b00 gives P=8, 2'b01 gives P=16 and 2'b10 gives P=32. The output period is B·P + A input clocks.
- R2: The select code 2'b11 is treated as 2'b00 (P=8).
- R3: In every period, `swallow_o` is high for the first A·(P+1) input clocks. It is low for the remaining (B−A)·P clocks, where the prescaler divides by P.
- R4: `pulse_o` is high for exactly one input clock per period. It is registered, and it rises on the clock edge that closes the period.
- R5: A setting sampled at a reload with B < A or B < 3 is illegal. One clock later `cfg_err_o` rises. It stays high, with `pulse_o` and `swallow_o` low, until some clock samples a legal setting. That clock clears the flag and starts a full period. The pulse that closes the last good period is still issued.
- R6: A change of A, B or the select during a period has no effect until the next reload. The current period keeps its old length.
- R7: During reset all outputs are low. The first clock edge after reset is released samples the setting.
- R8: A = 0 gives a period of B·P with `swallow_o` always low. A = B gives a period of B·(P+1) with `swallow_o` high for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock being divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 5 | Swallow count A |
| b_i | input | 13 | Main count B |
| psel_i | input | 2 | Modulus pair select |
| pulse_o | output | 1 | One-clock pulse per division period |
| swallow_o | output | 1 | High while the prescaler divides by P+1 |
| cfg_err_o | output | 1 | Illegal setting sampled; divider held |

## Verification
The assertions assume that `a_i`, `b_i` and `psel_i` are stable at each clock edge. They also assume that the check made at a reload uses only the values present at that edge. The bench therefore changes these inputs only on falling edges. The pulse-width property relies on a legal period of at least 24 clocks. The bench reaches its illegal settings only through the error path, where the assertions expect no pulse. The stimulus covers every select code and both A boundaries (zero and equal to B). It also changes the setting in the middle of a period and drives two different illegal settings before recovering.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int unsigned A_W   = 5;
  localparam int unsigned B_W   = 13;
  localparam int unsigned PRE_W = 6;

  typedef enum logic [1:0] {
    PSEL_8   = 2'b00,
    PSEL_16  = 2'b01,
    PSEL_32  = 2'b10,
    PSEL_RSV = 2'b11
  } psel_e;

  // lower modulus P of the selected pair; reserved code falls back to 8
  function automatic logic [PRE_W-1:0] mod_of(input logic [1:0] sel);
    case (psel_e'(sel))
      PSEL_16: mod_of = PRE_W'(16);
      PSEL_32: mod_of = PRE_W'(32);
      default: mod_of = PRE_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/psw_cfg_check.sv
module psw_cfg_check
  import psw_pkg::*;
#(
  parameter int unsigned A_W   = psw_pkg::A_W,
  parameter int unsigned B_W   = psw_pkg::B_W,
  parameter int unsigned PRE_W = psw_pkg::PRE_W,
  parameter int unsigned MIN_B = 3
) (
  input  logic [A_W-1:0]   a_i,
  input  logic [B_W-1:0]   b_i,
  input  logic [1:0]       psel_i,
  output logic             ok_o,
  output logic [PRE_W-1:0] p_o
);
  localparam int unsigned PAD_W = B_W - A_W;

  logic [B_W-1:0] a_ext;
  assign a_ext = {{PAD_W{1'b0}}, a_i};
  assign ok_o  = (b_i >= a_ext) && (b_i >= B_W'(MIN_B));
  assign p_o   = mod_of(psel_i);
endmodule

// File: rtl/psw_prescaler.sv
module psw_prescaler #(
  parameter int unsigned PRE_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             load_hi_i,
  input  logic [PRE_W-1:0] load_p_i,
  input  logic             en_i,
  input  logic             next_hi_i,
  output logic             tc_o
);
  logic [PRE_W-1:0] p_q;
  logic [PRE_W-1:0] cnt_q;

  assign tc_o = (cnt_q == '0);

  // counts m-1 .. 0, m being P+1 (hi) or P
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q   <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      p_q   <= load_p_i;
      cnt_q <= load_hi_i ? load_p_i : load_p_i - 1'b1;
    end else if (en_i) begin
      if (tc_o) cnt_q <= next_hi_i ? p_q : p_q - 1'b1;
      else      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/psw_ab_counter.sv
module psw_ab_counter #(
  parameter int unsigned A_W = 5,
  parameter int unsigned B_W = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [A_W-1:0] a_ld_i,
  input  logic [B_W-1:0] b_ld_i,
  input  logic           step_i,
  output logic           a_nz_o,
  output logic           a_gt1_o,
  output logic           b_last_o
);
  logic [A_W-1:0] a_q;
  logic [B_W-1:0] b_q;

  assign a_nz_o   = (a_q != '0);
  assign a_gt1_o  = (a_q > A_W'(1));
  assign b_last_o = (b_q == B_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (load_i) begin
      a_q <= a_ld_i;
      b_q <= b_ld_i;
    end else if (step_i) begin
      b_q <= b_q - 1'b1;
      if (a_nz_o) a_q <= a_q - 1'b1;
    end
  end
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import psw_pkg::*;
#(
  parameter int unsigned A_W   = psw_pkg::A_W,
  parameter int unsigned B_W   = psw_pkg::B_W,
  parameter int unsigned MIN_B = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  input  logic [1:0]     psel_i,
  output logic           pulse_o,
  output logic           swallow_o,
  output logic           cfg_err_o
);
  localparam int unsigned PW = psw_pkg::PRE_W;

  logic          pend_q, err_q, pulse_q;
  logic          cfg_ok;
  logic [PW-1:0] cfg_p;
  logic          pre_tc, a_nz, a_gt1, b_last;
  logic          run, terminal, reload, load, step;

  psw_cfg_check #(.A_W(A_W), .B_W(B_W), .PRE_W(PW), .MIN_B(MIN_B)) i_cfg (
    .a_i(a_i), .b_i(b_i), .psel_i(psel_i), .ok_o(cfg_ok), .p_o(cfg_p)
  );

  assign run      = ~pend_q;
  assign terminal = run & pre_tc & b_last;
  assign reload   = pend_q | terminal;
  assign load     = reload & cfg_ok;
  assign step     = run & pre_tc & ~terminal;

  psw_prescaler #(.PRE_W(PW)) i_pre (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(load), .load_hi_i(a_i != '0), .load_p_i(cfg_p),
    .en_i(run & ~terminal), .next_hi_i(a_gt1),
    .tc_o(pre_tc)
  );

  psw_ab_counter #(.A_W(A_W), .B_W(B_W)) i_ab (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(load), .a_ld_i(a_i), .b_ld_i(b_i), .step_i(step),
    .a_nz_o(a_nz), .a_gt1_o(a_gt1), .b_last_o(b_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b1;
      err_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= terminal;
      if (reload) begin
        pend_q <= ~cfg_ok;
        err_q  <= ~cfg_ok;
      end
    end
  end

  assign pulse_o   = pulse_q;
  assign cfg_err_o = err_q;
  assign swallow_o = run & a_nz;
endmodule

// File: rtl/psw_div_chk.sv
module psw_div_chk #(
  parameter int unsigned A_W   = 5,
  parameter int unsigned B_W   = 13,
  parameter int unsigned MIN_B = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [A_W-1:0] a_i,
  input logic [B_W-1:0] b_i,
  input logic           pulse_o,
  input logic           swallow_o,
  input logic           cfg_err_o
);
  localparam int unsigned PAD_W = B_W - A_W;

  AST_PULSE_ONE_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o); // R4

  AST_ERR_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_o && $past(cfg_err_o)) |-> !pulse_o); // R5

  AST_ERR_NO_SWALLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !swallow_o); // R5

  AST_RELOAD_CHECKS_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> (cfg_err_o == (($past(b_i) < {{PAD_W{1'b0}}, $past(a_i)}) ||
                               ($past(b_i) < B_W'(MIN_B))))); // R6

  AST_SWALLOW_AT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && !cfg_err_o) |-> (swallow_o == ($past(a_i) != '0))); // R3
endmodule

bind pulse_swallow_div psw_div_chk #(.A_W(A_W), .B_W(B_W), .MIN_B(MIN_B)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i),
  .pulse_o(pulse_o), .swallow_o(swallow_o), .cfg_err_o(cfg_err_o)
);

// File: tb/test_pulse_swallow_div.sv
module test_pulse_swallow_div;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  a_in = '0;
  logic [12:0] b_in = '0;
  logic [1:0]  sel_in = '0;
  logic        pulse, swallow, cfg_err;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  // reference model state
  bit m_pend = 1'b1, m_err = 1'b0, m_pulse = 1'b0, m_swl = 1'b0;
  int m_rem = 0, m_n = 0, m_swl_len = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_swallow_div i_pulse_swallow_div (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a_in), .b_i(b_in), .psel_i(sel_in),
    .pulse_o(pulse), .swallow_o(swallow), .cfg_err_o(cfg_err)
  );

  function automatic int p_of(input logic [1:0] s);
    case (s)
      2'b01:   return 16;
      2'b10:   return 32;
      default: return 8;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_pend = 1'b1; m_err = 1'b0; m_pulse = 1'b0; m_swl = 1'b0;
    end else begin
      if (m_pend || m_rem == 1) begin
        int p, a, b;
        m_pulse = !m_pend;
        p = p_of(sel_in); a = int'(a_in); b = int'(b_in);
        if (b >= a && b >= 3) begin
          m_n = b * p + a; m_rem = m_n; m_swl_len = a * (p + 1);
          m_pend = 1'b0; m_err = 1'b0;
        end else begin
          m_pend = 1'b1; m_err = 1'b1;
        end
      end else begin
        m_rem--;
        m_pulse = 1'b0;
      end
      m_swl = !m_pend && ((m_n - m_rem) < m_swl_len);
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      check(pulse == m_pulse, "R4 pulse_o", int'(pulse), int'(m_pulse));
      check(cfg_err == m_err, "R5 cfg_err_o", int'(cfg_err), int'(m_err));
      check(swallow == m_swl, "R3 swallow_o", int'(swallow), int'(m_swl));
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic set_cfg(input logic [1:0] s, input int a, input int b);
    sel_in = s; a_in = 5'(a); b_in = 13'(b);
  endtask

  task automatic wait_pulse();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (pulse) return;
    end
  endtask

  // assumes called right after a pulse was observed
  task automatic measure(input int exp, input string tag);
    int n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      n++;
      if (pulse) break;
    end
    check(n == exp, tag, n, exp);
  endtask

  task automatic count_swallow(input int exp, input string tag);
    int n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (swallow) n++;
      if (pulse) break;
    end
    check(n == exp, tag, n, exp);
  endtask

  initial begin
    set_cfg(2'b00, 2, 5);
    repeat (3) @(negedge clk);
    check(pulse == 1'b0, "R7 pulse in reset", int'(pulse), 0);
    check(cfg_err == 1'b0, "R7 err in reset", int'(cfg_err), 0);
    check(swallow == 1'b0, "R7 swallow in reset", int'(swallow), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(swallow == 1'b1, "R7 first edge loads", int'(swallow), 1);

    wait_pulse(); measure(42, "R1 P=8 a2 b5");
    count_swallow(18, "R3 swallow length P=8");

    set_cfg(2'b01, 3, 4);
    wait_pulse(); measure(67, "R1 P=16 a3 b4");
    count_swallow(51, "R3 swallow length P=16");

    set_cfg(2'b10, 31, 40);
    wait_pulse(); measure(1311, "R1 P=32 a31 b40");

    set_cfg(2'b11, 1, 3);
    wait_pulse(); measure(25, "R2 reserved select");

    set_cfg(2'b00, 0, 3);
    wait_pulse(); measure(24, "R8 a zero");
    count_swallow(0, "R8 no swallow");

    set_cfg(2'b00, 5, 5);
    wait_pulse(); measure(45, "R8 a equals b");
    count_swallow(45, "R8 full swallow");

    // mid-period change
    wait_pulse();
    repeat (5) @(negedge clk);
    set_cfg(2'b01, 0, 3);
    begin
      int n = 5;
      for (int i = 0; i < 5000; i++) begin
        @(negedge clk);
        n++;
        if (pulse) break;
      end
      check(n == 45, "R6 period unchanged", n, 45);
    end
    measure(48, "R6 new setting next period");

    // illegal settings
    set_cfg(2'b00, 5, 4);
    wait_pulse();
    check(cfg_err == 1'b1, "R5 b below a flags", int'(cfg_err), 1);
    repeat (60) @(negedge clk);
    set_cfg(2'b00, 0, 2);
    repeat (60) @(negedge clk);
    check(cfg_err == 1'b1, "R5 b below min flags", int'(cfg_err), 1);
    check(pulse == 1'b0, "R5 held", int'(pulse), 0);
    set_cfg(2'b00, 1, 3);
    @(negedge clk);
    check(cfg_err == 1'b0, "R5 recovers", int'(cfg_err), 0);
    measure(25, "R5 full period after recovery");
    measure(25, "R1 steady after recovery");

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule